// File: doc/BRIEF.md
# Eight-bit accumulator processor core

This block is a compact multi-cycle processor with an 8-bit data path and a 16-bit address space. It keeps two general registers (A and B), a program counter, an operand address register and a four-bit condition register. It reaches the outside world through one synchronous memory port that carries an address, write data, read data and separate read and write strobes. Each instruction starts with a one-byte opcode fetch. Any operand bytes are read next, and the instruction then executes.

The instruction set covers register loads (immediate and absolute), stores of A or B to an absolute address, moves between A and B, addition and subtraction into A (with an immediate, absolute or B operand), an unconditional jump, a no-operation and a halt. A halt freezes every register until the reset input is asserted again. The core is meant to be paired with a single-cycle-latency memory or ROM/RAM pair and driven from a reset vector at address zero.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low, `halted`, `mem_rd` and `mem_wr` are 0 and `flags` is 0. After release, the first strobe is a read (`mem_rd`=1) at address 0x0000.
- R2: Opcodes are 0x00 no-op, 0x01 halt, 0x10/0x11 load A immediate/absolute, 0x12/0x13 load B immediate/absolute, 0x20/0x21 store A/B absolute, 0x30 copy A into B, 0x31 copy B into A, 0x40/0x41/0x42 add immediate/absolute/B, 0x50/0x51/0x52 subtract immediate/absolute/B, 0x60 jump absolute. An immediate operand is the single byte after the opcode. An absolute operand is the two bytes after the opcode, low byte first.
- R3: Read data is taken from `mem_rdata` in the clock cycle after the one in which `mem_rd` was high.
- R4: A load puts the operand byte into A or B. A store drives the selected register on `mem_wdata` with `mem_wr` high for exactly one cycle at the absolute address.
- R5: Copy A into B (0x30) and copy B into A (0x31) move the full byte between the registers.
- R6: Add writes A+operand (mod 256) into A. `flags` is {N,V,Z,C} on bits 3..0: N is result bit 7, Z is set when the result is 0, C is the unsigned carry out, and V flags a signed overflow.
- R7: Subtract writes A-operand (mod 256) into A. C is 1 when no borrow occurs (A >= operand, unsigned) and 0 otherwise. N, Z and V follow the R6 rules for two's-complement subtraction.
- R8: Loads, stores, copies, jump, no-op and halt leave `flags` unchanged.
- R9: A jump sets the program counter to its 16-bit target. The next opcode fetch reads from the target, and bytes after the jump are not executed.
- R10: An opcode not listed in R2 behaves as a one-byte no-op.
- R11: After a halt, `halted` is 1 and no read or write strobe is issued until reset. A reset restarts execution at 0x0000.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Store data |
| mem_rd | output | 1 | Read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data |
| flags | output | 4 | Condition bits {N,V,Z,C} |
| halted | output | 1 | High while stopped by a halt instruction |

## Verification
The bench builds the core with its default parameters: a 16-bit address and a reset vector of zero. It attaches a 1024-byte memory model that answers reads one cycle late. Data and store targets sit in pages 0x02 and 0x03, so a nonzero high address byte tests the low-byte-first operand order. A jump over a store tests that skipped bytes are never executed.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam int DW = 8;
  localparam int AW = 16;

  localparam logic [DW-1:0] OP_NOP   = 8'h00;
  localparam logic [DW-1:0] OP_BRK   = 8'h01;
  localparam logic [DW-1:0] OP_LDA_I = 8'h10;
  localparam logic [DW-1:0] OP_LDA_M = 8'h11;
  localparam logic [DW-1:0] OP_LDB_I = 8'h12;
  localparam logic [DW-1:0] OP_LDB_M = 8'h13;
  localparam logic [DW-1:0] OP_STA   = 8'h20;
  localparam logic [DW-1:0] OP_STB   = 8'h21;
  localparam logic [DW-1:0] OP_TAB   = 8'h30;
  localparam logic [DW-1:0] OP_TBA   = 8'h31;
  localparam logic [DW-1:0] OP_ADD_I = 8'h40;
  localparam logic [DW-1:0] OP_ADD_M = 8'h41;
  localparam logic [DW-1:0] OP_ADD_B = 8'h42;
  localparam logic [DW-1:0] OP_SUB_I = 8'h50;
  localparam logic [DW-1:0] OP_SUB_M = 8'h51;
  localparam logic [DW-1:0] OP_SUB_B = 8'h52;
  localparam logic [DW-1:0] OP_JMP   = 8'h60;

  // sequencer phases
  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_IMM, S_IMM_EX, S_ALO, S_AHI,
    S_ALAT, S_MEM, S_MEM_EX, S_HALT
  } state_e;

  // operation class
  typedef enum logic [3:0] {
    C_NOP, C_BRK, C_LDA, C_LDB, C_STA, C_STB,
    C_TAB, C_TBA, C_ADD, C_SUB, C_JMP
  } cls_e;

  // operand source
  typedef enum logic [1:0] {M_IMP, M_IMM, M_ABS, M_REG} mode_e;

  typedef struct packed {
    cls_e  cls;
    mode_e mode;
  } dec_t;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/acc8_rst_sync.sv
module acc8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [DW-1:0] op,
  output dec_t          dec
);
  always_comb begin
    dec = '{cls: C_NOP, mode: M_IMP};
    case (op)
      OP_BRK:   dec.cls = C_BRK;
      OP_LDA_I: dec = '{cls: C_LDA, mode: M_IMM};
      OP_LDA_M: dec = '{cls: C_LDA, mode: M_ABS};
      OP_LDB_I: dec = '{cls: C_LDB, mode: M_IMM};
      OP_LDB_M: dec = '{cls: C_LDB, mode: M_ABS};
      OP_STA:   dec = '{cls: C_STA, mode: M_ABS};
      OP_STB:   dec = '{cls: C_STB, mode: M_ABS};
      OP_TAB:   dec.cls = C_TAB;
      OP_TBA:   dec.cls = C_TBA;
      OP_ADD_I: dec = '{cls: C_ADD, mode: M_IMM};
      OP_ADD_M: dec = '{cls: C_ADD, mode: M_ABS};
      OP_ADD_B: dec = '{cls: C_ADD, mode: M_REG};
      OP_SUB_I: dec = '{cls: C_SUB, mode: M_IMM};
      OP_SUB_M: dec = '{cls: C_SUB, mode: M_ABS};
      OP_SUB_B: dec = '{cls: C_SUB, mode: M_REG};
      OP_JMP:   dec = '{cls: C_JMP, mode: M_ABS};
      default:  dec = '{cls: C_NOP, mode: M_IMP};
    endcase
  end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output flags_t       fl
);
  logic [W-1:0] bx;
  logic [W:0]   sum;

  always_comb begin
    bx   = sub ? ~b : b;
    sum  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
    res  = sum[W-1:0];
    fl.c = sum[W];
    fl.z = (res == '0);
    fl.n = res[W-1];
    fl.v = (a[W-1] == bx[W-1]) && (res[W-1] != a[W-1]);
  end
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [3:0]    flags,
  output logic          halted
);
  localparam int HW = AW - DW;

  logic rst_ns;

  state_e        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] ar_q, ar_d;
  logic [DW-1:0] ir_q, ir_d;
  logic [DW-1:0] a_q, a_d;
  logic [DW-1:0] b_q, b_d;
  flags_t        fl_q, fl_d;

  logic [DW-1:0] dec_in;
  dec_t          dec;
  logic [DW-1:0] alu_b, alu_res;
  flags_t        alu_fl;
  logic          run, exec, rd_c, wr_c;
  logic [AW-1:0] addr_c;

  acc8_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ns(rst_ns)
  );

  // opcode is live on the read bus in the decode phase, held afterwards
  assign dec_in = (state_q == S_DECODE) ? mem_rdata : ir_q;

  acc8_decode u_dec (
    .op (dec_in),
    .dec(dec)
  );

  assign alu_b = (dec.mode == M_REG) ? b_q : mem_rdata;

  acc8_alu #(.W(DW)) u_alu (
    .a  (a_q),
    .b  (alu_b),
    .sub(dec.cls == C_SUB),
    .res(alu_res),
    .fl (alu_fl)
  );

  // clock enable: running out of reset and not stopped
  assign run = rst_ns && (state_q != S_HALT);

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ar_d    = ar_q;
    ir_d    = ir_q;
    a_d     = a_q;
    b_d     = b_q;
    fl_d    = fl_q;
    addr_c  = pc_q;
    rd_c    = 1'b0;
    wr_c    = 1'b0;
    exec    = 1'b0;

    case (state_q)
      S_FETCH: begin
        rd_c    = 1'b1;
        pc_d    = pc_q + AW'(1);
        state_d = S_DECODE;
      end
      S_DECODE: begin
        ir_d = mem_rdata;
        case (dec.mode)
          M_IMM:   state_d = S_IMM;
          M_ABS:   state_d = S_ALO;
          default: begin
            exec    = 1'b1;
            state_d = S_FETCH;
          end
        endcase
      end
      S_IMM: begin
        rd_c    = 1'b1;
        pc_d    = pc_q + AW'(1);
        state_d = S_IMM_EX;
      end
      S_IMM_EX: begin
        exec    = 1'b1;
        state_d = S_FETCH;
      end
      S_ALO: begin
        rd_c    = 1'b1;
        pc_d    = pc_q + AW'(1);
        state_d = S_AHI;
      end
      S_AHI: begin
        ar_d[DW-1:0] = mem_rdata;
        rd_c         = 1'b1;
        pc_d         = pc_q + AW'(1);
        state_d      = S_ALAT;
      end
      S_ALAT: begin
        ar_d[AW-1:DW] = mem_rdata[HW-1:0];
        if (dec.cls == C_JMP) begin
          pc_d    = {mem_rdata[HW-1:0], ar_q[DW-1:0]};
          state_d = S_FETCH;
        end else begin
          state_d = S_MEM;
        end
      end
      S_MEM: begin
        addr_c = ar_q;
        if (dec.cls == C_STA || dec.cls == C_STB) begin
          wr_c    = 1'b1;
          state_d = S_FETCH;
        end else begin
          rd_c    = 1'b1;
          state_d = S_MEM_EX;
        end
      end
      S_MEM_EX: begin
        exec    = 1'b1;
        state_d = S_FETCH;
      end
      S_HALT:  state_d = S_HALT;
      default: state_d = S_FETCH;
    endcase

    if (exec) begin
      case (dec.cls)
        C_LDA: a_d = mem_rdata;
        C_LDB: b_d = mem_rdata;
        C_TAB: b_d = a_q;
        C_TBA: a_d = b_q;
        C_ADD, C_SUB: begin
          a_d  = alu_res;
          fl_d = alu_fl;
        end
        C_BRK:   state_d = S_HALT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_FETCH;
      pc_q    <= RESET_VEC;
      ar_q    <= '0;
      ir_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      fl_q    <= '0;
    end else if (run) begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ar_q    <= ar_d;
      ir_q    <= ir_d;
      a_q     <= a_d;
      b_q     <= b_d;
      fl_q    <= fl_d;
    end
  end

  assign mem_addr  = addr_c;
  assign mem_wdata = (dec.cls == C_STB) ? b_q : a_q;
  assign mem_rd    = rd_c & run;
  assign mem_wr    = wr_c & run;
  assign flags     = fl_q;
  assign halted    = (state_q == S_HALT);
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk
  import acc8_pkg::*;
#(
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input logic          clk,
  input logic          rst_ns,
  input state_e        state,
  input dec_t          dec,
  input logic [DW-1:0] ar_lo,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_rdata,
  input logic [3:0]    flags,
  input logic          halted
);
  // R1: first action after reset release is an opcode read at the vector
  p_first_fetch_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(rst_ns) |-> (mem_rd && mem_addr == RESET_VEC));

  // R12: the two strobes are exclusive
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    !(mem_rd && mem_wr));

  // R11: a halted core stays halted and silent
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    halted |=> (halted && !mem_rd && !mem_wr));

  // R8: the condition bits move only after an add or subtract
  p_flags_alu_only_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(flags) |-> ($past(dec.cls) == C_ADD || $past(dec.cls) == C_SUB));

  // R9: a jump fetches from the assembled target next
  p_jump_target_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (state == S_ALAT && dec.cls == C_JMP) |=>
      (mem_rd && mem_addr == $past({mem_rdata[AW-DW-1:0], ar_lo})));

  // R4: writes come only from store instructions
  p_store_only_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_wr |-> (dec.cls == C_STA || dec.cls == C_STB));
endmodule

bind acc8_core acc8_core_chk #(.RESET_VEC(RESET_VEC)) u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .state    (state_q),
  .dec      (dec),
  .ar_lo    (ar_q[acc8_pkg::DW-1:0]),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_rdata(mem_rdata),
  .flags    (flags),
  .halted   (halted)
);

// File: tb/acc8_core_bench.sv
module acc8_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [3:0]  flags;
  logic        halted;

  always #2 clk = ~clk;

  acc8_core u_acc8_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .flags(flags), .halted(halted)
  );

  // memory model: read data appears the cycle after the strobe (R3)
  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  int checks = 0;
  int errors = 0;
  int wp = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    mem[wp] <= b;
    wp++;
  endtask
  task automatic op1(logic [7:0] o);                put(o); endtask
  task automatic op2(logic [7:0] o, logic [7:0] v); put(o); put(v); endtask
  task automatic op3(logic [7:0] o, logic [15:0] a);
    put(o); put(a[7:0]); put(a[15:8]);
  endtask

  // driver side of the scoreboard
  task automatic expect_wr(logic [15:0] a, logic [7:0] d, string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  // monitor side: pops one item per observed write
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_wr) begin
        checks++; errors++;
        $display("FAIL R12 actual rd=1 wr=1 expected not both");
      end
      if (halted && (mem_rd || mem_wr)) begin
        checks++; errors++;
        $display("FAIL R11 actual strobe while halted expected none");
      end
      if (mem_wr) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 actual write %0h=%0h expected no write", mem_addr, mem_wdata);
        end else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {8'h00, mem_addr, mem_wdata}, {8'h00, e});
        end
      end
    end
  end

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
    wp = 0;
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic go(logic [3:0] fl_exp, string fl_tag);
    int n;
    @(negedge clk);
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    check("R1 strobes in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
    check("R1 flags in reset", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    n = 0;
    while (!mem_rd && n < 20) begin @(negedge clk); n++; end
    check("R1 first fetch address", {16'd0, mem_addr}, 32'h0000);
    check("R1 first fetch strobe", {31'd0, mem_rd}, 32'd1);
    n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    check("R11 halted after halt opcode", {31'd0, halted}, 32'd1);
    repeat (8) @(negedge clk);
    check("R11 still halted", {31'd0, halted}, 32'd1);
    check("R4 all expected stores seen", exp_q.size(), 32'd0);
    check(fl_tag, {28'd0, flags}, {28'd0, fl_exp});
  endtask

  initial begin
    // P1: immediate load and add, store (R2 R4 R6)
    begin_prog();
    op2(8'h10, 8'h05); op2(8'h40, 8'h03); op3(8'h20, 16'h0200); op1(8'h01);
    expect_wr(16'h0200, 8'h08, "R2/R6 add immediate");
    go(4'b0000, "R6 flags plain add");

    // P2: signed overflow, then copy and load leave flags (R5 R6 R8)
    begin_prog();
    op2(8'h10, 8'h7F); op2(8'h40, 8'h01); op3(8'h20, 16'h0201);
    op1(8'h30); op3(8'h21, 16'h0202); op2(8'h12, 8'h05); op1(8'h01);
    expect_wr(16'h0201, 8'h80, "R6 overflow sum");
    expect_wr(16'h0202, 8'h80, "R5 copy A into B");
    go(4'b1100, "R8/R6 flags after overflow and loads");

    // P3: carry out and zero (R6)
    begin_prog();
    op2(8'h10, 8'hFF); op2(8'h40, 8'h01); op3(8'h20, 16'h0203); op1(8'h01);
    expect_wr(16'h0203, 8'h00, "R6 wrap to zero");
    go(4'b0011, "R6 flags carry zero");

    // P4: absolute operands, low byte first (R2 R3 R4 R7)
    begin_prog();
    op3(8'h11, 16'h0300); op3(8'h51, 16'h0301); op3(8'h20, 16'h0204);
    op3(8'h13, 16'h0302); op3(8'h21, 16'h020A);
    op3(8'h41, 16'h0302); op3(8'h20, 16'h020B); op1(8'h01);
    mem[16'h0300] <= 8'h10; mem[16'h0301] <= 8'h20; mem[16'h0302] <= 8'h44;
    expect_wr(16'h0204, 8'hF0, "R7/R3 subtract absolute with borrow");
    expect_wr(16'h020A, 8'h44, "R4/R2 load B absolute");
    expect_wr(16'h020B, 8'h34, "R6/R3 add absolute carry");
    go(4'b0001, "R6 flags after absolute add");

    // P5: subtract forms and register copies (R5 R7)
    begin_prog();
    op2(8'h12, 8'h30); op2(8'h10, 8'h80); op2(8'h50, 8'h01); op3(8'h20, 16'h0205);
    op1(8'h52); op3(8'h20, 16'h0206); op1(8'h31); op3(8'h20, 16'h0207);
    op1(8'h42); op3(8'h20, 16'h0208); op2(8'h12, 8'h60); op1(8'h52);
    op3(8'h20, 16'h020C); op1(8'h01);
    expect_wr(16'h0205, 8'h7F, "R7 subtract immediate signed overflow");
    expect_wr(16'h0206, 8'h4F, "R7 subtract B");
    expect_wr(16'h0207, 8'h30, "R5 copy B into A");
    expect_wr(16'h0208, 8'h60, "R6 add B");
    expect_wr(16'h020C, 8'h00, "R7 equal operands give zero");
    go(4'b0011, "R7 flags equal subtract");

    // P6: jump over a store, undefined opcodes, store after halt (R9 R10 R11)
    begin_prog();
    op2(8'h10, 8'hFF); op2(8'h40, 8'h01); op2(8'h10, 8'h11);
    op3(8'h60, 16'h0040); op3(8'h20, 16'h020F);
    wp = 16'h0040;
    op1(8'hEE); op1(8'h7A); op1(8'h00); op3(8'h20, 16'h0209);
    op1(8'h01); op3(8'h20, 16'h020D);
    expect_wr(16'h0209, 8'h11, "R10/R9 store after jump and undefined opcodes");
    go(4'b0011, "R8/R10 flags kept across jump and no-ops");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule